// File: doc/BRIEF.md
# Interval Timer Down-Counter Channel

This block is one channel of a programmable interval timer. A processor writes a control byte and then a start count of up to 16 bits, one byte at a time, through a small write port. The channel then divides a timer clock. It produces either a 50% duty square wave or a rate pulse, one low tick per period, on its `out` pin. The count is read as plain binary or as four BCD digits, as the control byte selects. A `gate` input pauses the channel and restarts it.

The timer clock arrives as `tick`, a one-cycle enable sampled on the system clock `clk`. Every timer event is therefore one rising edge of `clk` with `tick` high. Each register of the channel lives in the `clk` domain. Several channels can share one write bus, and each one claims only the control bytes whose select field matches its `CHAN_ID` parameter.

Top module: `pit_channel`

## Requirements
- R1: After reset `out` is 1. Count writes made before any control byte is accepted are ignored, and `out` stays 1.
- R2: A control byte is a write with `wr_ctl`=1. Bits 7:6 must equal `CHAN_ID` or the byte is ignored. Bits 5:4 set the load format: 01 low byte only (high byte taken as 0), 10 high byte only (low byte taken as 0), 11 low byte then high byte. A byte with 00 in bits 5:4 has no effect.
- R3: Bits 3:1 of the control byte are the mode, with bit 3 ignored whenever bit 2 is 1. x10 selects the rate pulse and x11 selects the square wave. Codes 000, 001, 100 and 101 are accepted but hold `out` at 1.
- R4: Control bit 0 = 1 reads the count as four BCD digits (0x1000 gives a period of 1000 ticks). Bit 0 = 0 reads the count as binary.
- R5: In low-then-high format, counting does not start until the high byte is written. Between the two byte writes `out` stays 1.
- R6: In square-wave mode with span N, `out` is low for floor(N/2) ticks and high for N−floor(N/2) ticks in every period.
- R7: In rate mode with span N (N ≥ 2), `out` is low for exactly 1 tick and high for N−1 ticks in every period.
- R8: A loaded count of 0 gives a span of 65536 in binary and 10000 in BCD.
- R9: While `gate` is 0, counting is suspended and `out` is 1. Once `gate` returns to 1, the next tick reloads the full span, so in square-wave mode `out` stays 1 for N−floor(N/2) ticks after the reload.
- R10: An accepted control byte stops the channel and drives `out` to 1 from the next cycle until a new count is complete.
- R11: The count advances only on cycles where `tick` is 1. The first tick after a count is complete loads the span, and `out` is 1 for that tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one byte per cycle |
| wr_ctl | input | 1 | 1: byte is a control byte, 0: byte is a count byte |
| wr_data | input | 8 | Write data |
| tick | input | 1 | Timer clock event, one `clk` cycle wide |
| gate | input | 1 | Count enable and restart |
| out | output | 1 | Timer waveform |

## Verification
The bench builds the channel with a 16-bit count and channel select 0, the defaults. At these values the binary zero-count half period of 32768 ticks and the BCD 10000-tick period can both be measured when `tick` is held high on every cycle. One run uses a tick every third cycle, which shows that idle cycles never shift the measured run lengths. Writes addressed to channel select 1, and latch-format bytes, are issued while a wave is being measured, so any disturbance they cause appears as a run of the wrong length.

// File: rtl/pit_pkg.sv
package pit_pkg;

  // Operating mode after decoding the 3-bit mode field
  typedef enum logic [2:0] {
    PM_TERM     = 3'd0,
    PM_RETRIG   = 3'd1,
    PM_RATE     = 3'd2,
    PM_SQUARE   = 3'd3,
    PM_SWSTROBE = 3'd4,
    PM_HWSTROBE = 3'd5
  } pit_mode_e;

  // Byte loading format from control bits 5:4
  typedef enum logic [1:0] {
    LF_LATCH = 2'b00,
    LF_LO    = 2'b01,
    LF_HI    = 2'b10,
    LF_LOHI  = 2'b11
  } pit_fmt_e;

  // Mode field decode: the top bit is a don't-care for codes x10 and x11
  function automatic pit_mode_e pit_decode_mode(input logic [2:0] m);
    pit_mode_e r;
    if (m[1:0] == 2'b10)      r = PM_RATE;
    else if (m[1:0] == 2'b11) r = PM_SQUARE;
    else if (m[2])            r = m[0] ? PM_HWSTROBE : PM_SWSTROBE;
    else                      r = m[0] ? PM_RETRIG : PM_TERM;
    return r;
  endfunction

  // Number of ticks in one period for a raw count of width w.
  // BCD: digit-weighted sum; zero means 10^(w/4). Binary: zero means 2^w.
  function automatic logic [32:0] pit_span(input logic [31:0] raw,
                                           input logic bcd, input int w);
    logic [32:0] acc;
    logic [32:0] scale;
    acc   = '0;
    scale = 33'd1;
    if (bcd) begin
      for (int i = 0; i < 8; i++) begin
        if (i < w / 4) begin
          acc   = acc + 33'(raw[4*i +: 4]) * scale;
          scale = scale * 33'd10;
        end
      end
      if (raw == 32'd0) acc = scale;
    end else begin
      acc = (raw == 32'd0) ? (33'd1 << w) : 33'(raw);
    end
    return acc;
  endfunction

  // Square-wave level: high while the remaining count exceeds half the span
  function automatic logic pit_sq_level(input logic [32:0] cnt,
                                        input logic [32:0] span);
    return cnt > (span >> 1);
  endfunction

endpackage

// File: rtl/pit_wr_port.sv
// Control byte decode and byte-wise count assembly. CNT_W from 9 to 16.
module pit_wr_port
  import pit_pkg::*;
#(
  parameter int          CNT_W   = 16,
  parameter logic [1:0]  CHAN_ID = 2'd0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_ctl,
  input  logic [7:0]       wr_data,
  output pit_mode_e        mode_o,
  output logic             bcd_o,
  output logic [CNT_W-1:0] raw_o,
  output logic             ctl_wr_o,
  output logic             load_done_o
);
  localparam int HI_W = CNT_W - 8;

  pit_fmt_e         fmt_q;
  pit_mode_e        mode_q;
  logic             bcd_q;
  logic [CNT_W-1:0] raw_q;
  logic             hi_next_q;
  logic             done_q;

  logic ctl_hit, cnt_hit, completes;

  assign ctl_hit = wr_en & wr_ctl & (wr_data[7:6] == CHAN_ID)
                 & (wr_data[5:4] != LF_LATCH);
  assign cnt_hit = wr_en & ~wr_ctl & (fmt_q != LF_LATCH);
  assign completes = (fmt_q == LF_LO) | (fmt_q == LF_HI)
                   | ((fmt_q == LF_LOHI) & hi_next_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fmt_q     <= LF_LATCH;
      mode_q    <= PM_TERM;
      bcd_q     <= 1'b0;
      raw_q     <= '0;
      hi_next_q <= 1'b0;
      done_q    <= 1'b0;
    end else if (ctl_hit) begin
      fmt_q     <= pit_fmt_e'(wr_data[5:4]);
      mode_q    <= pit_decode_mode(wr_data[3:1]);
      bcd_q     <= wr_data[0];
      hi_next_q <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      done_q <= cnt_hit & completes;
      if (cnt_hit) begin
        case (fmt_q)
          LF_LO: raw_q <= CNT_W'(wr_data);
          LF_HI: raw_q <= {wr_data[HI_W-1:0], 8'h00};
          LF_LOHI: begin
            if (!hi_next_q) raw_q[7:0]       <= wr_data;
            else            raw_q[CNT_W-1:8] <= wr_data[HI_W-1:0];
            hi_next_q <= ~hi_next_q;
          end
          default: ;
        endcase
      end
    end
  end

  assign mode_o      = mode_q;
  assign bcd_o       = bcd_q;
  assign raw_o       = raw_q;
  assign ctl_wr_o    = ctl_hit;
  assign load_done_o = done_q;

endmodule

// File: rtl/pit_gate_mon.sv
// Registers the gate input and flags its rising edge in the same cycle.
module pit_gate_mon (
  input  logic clk,
  input  logic rst_n,
  input  logic gate,
  output logic gate_q_o,
  output logic gate_rise_o
);
  logic gate_q;

  always_ff @(posedge clk) begin
    if (!rst_n) gate_q <= 1'b0;
    else        gate_q <= gate;
  end

  assign gate_q_o    = gate_q;
  assign gate_rise_o = gate & ~gate_q;

endmodule

// File: rtl/pit_down_core.sv
// Binary down-counter over the decoded span; reloads at 1 or on a pending load.
module pit_down_core #(
  parameter int LEN_W = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             gate_q,
  input  logic             arm,
  input  logic             restart,
  input  logic             stop,
  input  logic [LEN_W-1:0] span_in,
  output logic [LEN_W-1:0] cnt_o,
  output logic [LEN_W-1:0] span_o,
  output logic             active_o,
  output logic             reload_o
);
  logic             armed_q, pend_q;
  logic [LEN_W-1:0] cnt_q, span_q;
  logic             step, wrap;

  assign step = tick & armed_q & gate_q;
  assign wrap = pend_q | (cnt_q <= LEN_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      pend_q  <= 1'b0;
      cnt_q   <= '0;
      span_q  <= '0;
    end else if (stop) begin
      armed_q <= 1'b0;
      pend_q  <= 1'b0;
      cnt_q   <= '0;
    end else if (arm) begin
      armed_q <= 1'b1;
      pend_q  <= 1'b1;
      span_q  <= span_in;
    end else if (restart) begin
      pend_q <= 1'b1;
    end else if (step) begin
      if (wrap) begin
        cnt_q  <= span_q;
        pend_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q - LEN_W'(1);
      end
    end
  end

  assign cnt_o    = cnt_q;
  assign span_o   = span_q;
  assign active_o = armed_q & ~pend_q & gate_q;
  assign reload_o = ~stop & ~arm & ~restart & step & wrap;

endmodule

// File: rtl/pit_wave_shape.sv
// Output level from mode and counter state; idle or paused means high.
module pit_wave_shape
  import pit_pkg::*;
#(
  parameter int LEN_W = 17
) (
  input  pit_mode_e        mode,
  input  logic             active,
  input  logic [LEN_W-1:0] cnt,
  input  logic [LEN_W-1:0] span,
  output logic             out
);
  logic level;

  always_comb begin
    case (mode)
      PM_SQUARE: level = pit_sq_level(33'(cnt), 33'(span));
      PM_RATE:   level = (cnt != LEN_W'(1));
      default:   level = 1'b1;
    endcase
  end

  assign out = ~active | level;

endmodule

// File: rtl/pit_channel.sv
module pit_channel
  import pit_pkg::*;
#(
  parameter int         CNT_W   = 16,
  parameter logic [1:0] CHAN_ID = 2'd0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       wr_ctl,
  input  logic [7:0] wr_data,
  input  logic       tick,
  input  logic       gate,
  output logic       out
);
  localparam int LEN_W = CNT_W + 1;

  pit_mode_e        mode;
  logic             bcd;
  logic [CNT_W-1:0] raw;
  logic             ctl_wr, load_done;
  logic             gate_q, gate_rise;
  logic             is_wave, arm;
  logic [LEN_W-1:0] span_in, cnt, span;
  logic             active, reload;

  pit_wr_port #(.CNT_W(CNT_W), .CHAN_ID(CHAN_ID)) u_wr (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ctl(wr_ctl),
    .wr_data(wr_data), .mode_o(mode), .bcd_o(bcd), .raw_o(raw),
    .ctl_wr_o(ctl_wr), .load_done_o(load_done)
  );

  pit_gate_mon u_gate (
    .clk(clk), .rst_n(rst_n), .gate(gate),
    .gate_q_o(gate_q), .gate_rise_o(gate_rise)
  );

  assign is_wave = (mode == PM_RATE) | (mode == PM_SQUARE);
  assign arm     = load_done & is_wave;
  assign span_in = LEN_W'(pit_span(32'(raw), bcd, CNT_W));

  pit_down_core #(.LEN_W(LEN_W)) u_core (
    .clk(clk), .rst_n(rst_n), .tick(tick), .gate_q(gate_q),
    .arm(arm), .restart(gate_rise), .stop(ctl_wr), .span_in(span_in),
    .cnt_o(cnt), .span_o(span), .active_o(active), .reload_o(reload)
  );

  pit_wave_shape #(.LEN_W(LEN_W)) u_shape (
    .mode(mode), .active(active), .cnt(cnt), .span(span), .out(out)
  );

endmodule

// File: rtl/pit_channel_chk.sv
module pit_channel_chk
  import pit_pkg::*;
#(
  parameter int LEN_W = 17
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             out,
  input logic             ctl_wr,
  input logic             load_done,
  input logic             gate_q,
  input logic             gate_rise,
  input logic             active,
  input logic             reload,
  input logic [LEN_W-1:0] cnt,
  input logic [LEN_W-1:0] span,
  input pit_mode_e        mode
);
  // R10: accepted control byte forces the output high next cycle
  a_r10_ctl_forces_high: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> out);

  // R3: non-wave modes keep the output high
  a_r3_idle_modes_high: assert property (@(posedge clk) disable iff (!rst_n)
    !(mode == PM_RATE || mode == PM_SQUARE) |-> out);

  // R9: gate low means output high
  a_r9_gate_low_high: assert property (@(posedge clk) disable iff (!rst_n)
    !gate_q |-> out);

  // R7: the rate pulse lasts a single tick
  a_r7_single_low: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == PM_RATE && active && !out && tick && span > LEN_W'(1)) |=> out);

  // R6: running count stays inside the span; reload starts a high phase
  a_r6_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (cnt != '0 && cnt <= span));
  a_r6_reload_high: assert property (@(posedge clk) disable iff (!rst_n)
    (reload && span > LEN_W'(1)) |=> out);

  // R11: without a tick or a load event the count holds
  a_r11_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !ctl_wr && !load_done && !gate_rise) |=> $stable(cnt));

endmodule

bind pit_channel pit_channel_chk #(.LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .out(out), .ctl_wr(ctl_wr),
  .load_done(load_done), .gate_q(gate_q), .gate_rise(gate_rise),
  .active(active), .reload(reload), .cnt(cnt), .span(span), .mode(mode)
);

// File: tb/pit_channel_test.sv
`timescale 1ns/1ps
module pit_channel_test;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       wr_en = 1'b0, wr_ctl = 1'b0, tick = 1'b0, gate = 1'b1;
  logic [7:0] wr_data = 8'h00;
  logic       out;

  always #2 clk = ~clk;

  pit_channel #(.CNT_W(16), .CHAN_ID(2'd0)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ctl(wr_ctl),
    .wr_data(wr_data), .tick(tick), .gate(gate), .out(out)
  );

  typedef struct { logic lvl; int len; string req; } run_t;
  run_t exp_q[$];

  int   n_chk = 0, n_fail = 0;
  int   tick_div = 1, div_cnt = 0;
  bit   mon_en = 0, mon_skip = 0;
  logic mon_lvl = 1'b1;
  int   mon_len = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Monitor: measures run lengths in ticks, compares with the scoreboard queue;
  // afterwards drives the next tick.
  always @(negedge clk) begin
    run_t e;
    if (tick && mon_en) begin
      if (out !== mon_lvl) begin
        if (!mon_skip && exp_q.size() > 0) begin
          e = exp_q.pop_front();
          check(mon_lvl === e.lvl && mon_len == e.len, e.req,
                e.lvl ? "high run ticks" : "low run ticks", mon_len, e.len);
        end
        mon_skip = 0;
        mon_lvl  = out;
        mon_len  = 1;
      end else begin
        mon_len++;
      end
    end
    if (tick_div <= 1) tick = 1'b1;
    else begin
      div_cnt = (div_cnt + 1) % tick_div;
      tick    = (div_cnt == 0);
    end
  end

  // Independent span model from the requirement text
  function automatic int span_of(input bit bcd, input int raw);
    if (raw == 0) return bcd ? 10000 : 65536;
    if (bcd) return ((raw >> 12) & 15) * 1000 + ((raw >> 8) & 15) * 100
                  + ((raw >> 4) & 15) * 10 + (raw & 15);
    return raw;
  endfunction

  task automatic wr(input bit ctl, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_ctl = ctl; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic load(input logic [7:0] cw, input logic [7:0] lo,
                      input logic [7:0] hi);
    wr(1'b1, cw); wr(1'b0, lo); wr(1'b0, hi);
  endtask

  task automatic push_sq(input int n, input int pairs, input string req);
    repeat (pairs) begin
      exp_q.push_back(run_t'{1'b0, n / 2, req});
      exp_q.push_back(run_t'{1'b1, n - n / 2, req});
    end
  endtask

  task automatic push_rate(input int n, input int pairs, input string req);
    repeat (pairs) begin
      exp_q.push_back(run_t'{1'b0, 1, req});
      exp_q.push_back(run_t'{1'b1, n - 1, req});
    end
  endtask

  task automatic start_mon();
    mon_skip = 1; mon_lvl = 1'b1; mon_len = 0; mon_en = 1;
  endtask

  task automatic drain(input int max_cyc, input string req);
    int c = 0;
    while (exp_q.size() > 0 && c < max_cyc) begin
      @(negedge clk);
      c++;
    end
    if (exp_q.size() > 0) begin
      check(1'b0, req, "runs not observed", exp_q.size(), 0);
      exp_q.delete();
    end
    mon_en = 0;
  endtask

  task automatic hold_high(input int n, input string req);
    int lows = 0;
    repeat (n) begin
      @(negedge clk);
      if (out !== 1'b1) lows++;
    end
    check(lows == 0, req, "low samples while held", lows, 0);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog all: actual 190000 cycles expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] idle_cw [4] = '{8'h30, 8'h32, 8'h38, 8'h3A};
    int hc, c;

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(out === 1'b1, "R1", "out after reset", int'(out), 1);
    // R1: count bytes before any control byte are ignored
    wr(1'b0, 8'h05); wr(1'b0, 8'h00);
    hold_high(16, "R1");

    // R4 R6: BCD 0x1000 in square mode -> 1000-tick period
    load(8'h37, 8'h00, 8'h10);
    push_sq(span_of(1, 'h1000), 1, "R4 R6");
    start_mon(); drain(5000, "R6");

    // R6 R11: odd span, one tick every third cycle
    tick_div = 3;
    load(8'h36, 8'h07, 8'h00);
    push_sq(7, 2, "R6 R11");
    start_mon(); drain(400, "R11");
    tick_div = 1;

    // R3: mode field 110 behaves as rate mode; R7: plain rate mode
    load(8'h3C, 8'h05, 8'h00);
    push_rate(5, 2, "R3");
    start_mon(); drain(100, "R3");
    load(8'h34, 8'h03, 8'h00);
    push_rate(3, 2, "R7");
    start_mon(); drain(100, "R7");

    // R5: nothing happens between the low and high byte
    wr(1'b1, 8'h34); wr(1'b0, 8'h03);
    hold_high(12, "R5");
    wr(1'b0, 8'h00);
    push_rate(3, 2, "R5");
    start_mon(); drain(100, "R5");

    // R2: low-only format, then high-only format with BCD (R4)
    wr(1'b1, 8'h16); wr(1'b0, 8'h08);
    push_sq(8, 2, "R2");
    start_mon(); drain(100, "R2");
    wr(1'b1, 8'h27); wr(1'b0, 8'h01);
    push_sq(span_of(1, 'h0100), 1, "R2 R4");
    start_mon(); drain(400, "R4");

    // R2: other channel select and latch-format bytes have no effect
    load(8'h36, 8'h08, 8'h00);
    push_sq(8, 3, "R2");
    start_mon();
    repeat (10) @(negedge clk);
    wr(1'b1, 8'h76); wr(1'b1, 8'h06);
    drain(200, "R2");

    // R3: modes 0, 1, 4, 5 hold the output high
    for (int i = 0; i < 4; i++) begin
      load(idle_cw[i], 8'h06, 8'h00);
      hold_high(24, "R3");
    end

    // R8: zero count means maximum span
    load(8'h35, 8'h00, 8'h00);
    push_rate(span_of(1, 0), 1, "R8");
    start_mon(); drain(25000, "R8");
    load(8'h36, 8'h00, 8'h00);
    exp_q.push_back(run_t'{1'b0, span_of(0, 0) / 2, "R8"});
    start_mon(); drain(70000, "R8");

    // R9: gate low holds high; rise reloads and delays the next fall
    load(8'h36, 8'h06, 8'h00);
    repeat (30) @(negedge clk);
    gate = 1'b0;
    hold_high(10, "R9");
    gate = 1'b1;
    hc = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (out === 1'b1) hc++;
      else break;
    end
    check(hc == 4, "R9", "high samples after gate rise", hc, 4);

    // R10: control byte during a low phase forces high until reloaded
    load(8'h36, 8'h08, 8'h00);
    c = 0;
    while (out !== 1'b0 && c < 40) begin
      @(negedge clk);
      c++;
    end
    check(out === 1'b0, "R10", "low phase reached", int'(out), 0);
    wr(1'b1, 8'h36);
    check(out === 1'b1, "R10", "out after control byte", int'(out), 1);
    hold_high(20, "R10");
    wr(1'b0, 8'h04); wr(1'b0, 8'h00);
    push_sq(4, 2, "R10");
    start_mon(); drain(100, "R10");

    summary();
    $finish;
  end

endmodule